// File: doc/BRIEF.md
# Conversion-Start and Readout-Gate Timing Generator

This block drives a fast successive-approximation converter that delivers its result over a serial clocked link. It produces two periodic, phase-locked waveforms on a common period. The first is a conversion-start pulse. The second is a gate window during which a free-running bit clock may burst one sample out of the converter. All timing values are whole cycles of the block clock. The gate window opens a fixed number of cycles after each conversion rising edge. Its length is the sample width in bits times the bit-clock period, rounded up. The bit-clock period is given in quarter cycles of the block clock.

Software supplies a requested period, a pulse high time, a gate offset, a bit count and a bit-clock period. A rising edge on the run input starts the block. The pulse path is armed first, and the gate settings are checked second. If the gate settings cannot be honoured, the block drops back to idle without producing any edge. While the block runs, new settings take effect only at a period boundary, so no truncated pulse is ever produced. Stopping turns the gate off one cycle before the conversion path.

The `act_period_o` output reports the divider actually in use. This is the requested period after saturation.

Top module: `cnv_gate_timer`

## Requirements
- R1: After reset, `conv_o`, `gate_o` and `busy_o` are low and `act_period_o` is 0.
- R2: The requested period saturates to the range [PMIN, PMAX] cycles (5 and 500 by default) and is never refused for being out of range. `act_period_o` shows the saturated value once a start is accepted.
- R3: While running, `conv_o` rises every P cycles, where P is the saturated period, and stays high for the configured high time. The first rise comes two cycles after the run edge is sampled.
- R4: `gate_o` opens `offset` cycles after each conversion rise. It stays open for ceil(bits × q / 4) cycles, where q is the bit-clock period in quarter cycles.
- R5: A gate window that runs past the end of a period continues from phase 0 of the next period. In the first period after a start, that wrapped portion is not produced.
- R6: A run edge is refused when the high time is 0 or not less than P. `busy_o` then stays low.
- R7: A run edge is accepted for one cycle and then dropped when the offset is not less than P, or the gate length is 0 or not less than P. In that case `busy_o` is high for exactly one cycle and neither output rises.
- R8: When run falls, `gate_o` is low from the next cycle on. `conv_o` may finish an ongoing pulse for that one cycle (never starting a new one) and is low, with `busy_o` low, one cycle later.
- R9: Settings changed while running take effect only at the next period boundary. If the new set is invalid under R6 or R7, it is ignored and the current waveforms continue.
- R10: `busy_o` is high from an accepted run edge until the block has stopped. Only a rising edge of run starts the block, so holding run high after a refusal does not retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Level control; rising edge starts, low stops |
| cfg_period_i | input | CFGW | Requested period in cycles (saturated) |
| cfg_high_i | input | CFGW | Conversion pulse high time in cycles |
| cfg_offset_i | input | CFGW | Gate start delay after conversion rise, cycles |
| cfg_bits_i | input | BW | Sample width in bits |
| cfg_bclk_q_i | input | QW | Bit-clock period in quarter cycles |
| conv_o | output | 1 | Conversion-start pulse |
| gate_o | output | 1 | Readout bit-clock gate window |
| busy_o | output | 1 | Generator active |
| act_period_o | output | PW | Period in use (saturated divider) |

## Verification
The assertions assume that `run_i` and all configuration inputs are synchronous to `clk` and change only between edges. They also assume that PMIN is at least 2, so that a period boundary never coincides with the arming cycle. The bench drives every input on the falling edge and never changes settings asynchronously. It keeps its requested bit counts and bit-clock periods small enough that the products stay far inside 32-bit arithmetic. A behavioural model in the bench predicts all four outputs on every cycle from the input history alone. Directed measurements time the pulse period, high time, gate offset and gate length from observed edges.

// File: rtl/cnv_gate_pkg.sv
package cnv_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_STOP = 2'd3
  } tg_state_e;

  // Saturate a requested period into [lo, hi].
  function automatic int clamp_period(input int req, input int lo, input int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Gate length: bits times bit-clock period (fixed point, qf fraction bits), rounded up.
  function automatic int burst_len(input int bits, input int q, input int qf);
    return (bits * q + ((1 << qf) - 1)) >>> qf;
  endfunction

  // Gate window membership for phase ph within a period of per cycles.
  function automatic logic in_window(input int ph, input int off, input int len,
                                     input int per, input logic first);
    int stop_at;
    stop_at = off + len;
    if (stop_at <= per) return (ph >= off) && (ph < stop_at);
    return (ph >= off) || (!first && (ph < stop_at - per));
  endfunction

endpackage

// File: rtl/tg_cfg_eval.sv
module tg_cfg_eval
  import cnv_gate_pkg::*;
#(
  parameter int CFGW  = 16,
  parameter int BW    = 5,
  parameter int QW    = 6,
  parameter int QFRAC = 2,
  parameter int PMIN  = 5,
  parameter int PMAX  = 500,
  parameter int PW    = 9
) (
  input  logic [CFGW-1:0] cfg_period_i,
  input  logic [CFGW-1:0] cfg_high_i,
  input  logic [CFGW-1:0] cfg_offset_i,
  input  logic [BW-1:0]   cfg_bits_i,
  input  logic [QW-1:0]   cfg_bclk_q_i,
  output logic [PW-1:0]   per_o,
  output logic [PW-1:0]   high_o,
  output logic [PW-1:0]   off_o,
  output logic [PW-1:0]   len_o,
  output logic            conv_ok_o,
  output logic            gate_ok_o
);

  int per_i, high_i, off_i, len_i;

  always_comb begin
    per_i  = clamp_period(int'(cfg_period_i), PMIN, PMAX);
    high_i = int'(cfg_high_i);
    off_i  = int'(cfg_offset_i);
    len_i  = burst_len(int'(cfg_bits_i), int'(cfg_bclk_q_i), QFRAC);
  end

  assign conv_ok_o = (high_i != 0) && (high_i < per_i);
  assign gate_ok_o = (off_i < per_i) && (len_i != 0) && (len_i < per_i);

  assign per_o  = PW'(per_i);
  assign high_o = PW'(high_i);
  assign off_o  = PW'(off_i);
  assign len_o  = PW'(len_i);

endmodule

// File: rtl/tg_sequencer.sv
module tg_sequencer
  import cnv_gate_pkg::*;
#(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [PW-1:0] c_per_i,
  input  logic [PW-1:0] c_high_i,
  input  logic [PW-1:0] c_off_i,
  input  logic [PW-1:0] c_len_i,
  input  logic          c_conv_ok_i,
  input  logic          c_gate_ok_i,
  output tg_state_e     state_o,
  output logic [PW-1:0] ph_o,
  output logic          first_o,
  output logic [PW-1:0] sh_per_o,
  output logic [PW-1:0] sh_high_o,
  output logic [PW-1:0] sh_off_o,
  output logic [PW-1:0] sh_len_o
);

  tg_state_e     st;
  logic          run_q;
  logic          sh_gate_ok;
  logic [PW-1:0] ph;

  // Named events for the assertions and the decode stage.
  logic start_evt;
  logic period_end;
  logic cand_ok;

  assign start_evt  = run_i && !run_q;
  assign period_end = (ph == sh_per_o - PW'(1));
  assign cand_ok    = c_conv_ok_i && c_gate_ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      run_q      <= 1'b0;
      ph         <= '0;
      first_o    <= 1'b0;
      sh_gate_ok <= 1'b0;
      sh_per_o   <= '0;
      sh_high_o  <= '0;
      sh_off_o   <= '0;
      sh_len_o   <= '0;
    end else begin
      run_q <= run_i;
      case (st)
        ST_IDLE: begin
          if (start_evt && c_conv_ok_i) begin
            sh_per_o   <= c_per_i;
            sh_high_o  <= c_high_i;
            sh_off_o   <= c_off_i;
            sh_len_o   <= c_len_i;
            sh_gate_ok <= c_gate_ok_i;
            st         <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (run_i && sh_gate_ok) begin
            st      <= ST_RUN;
            ph      <= '0;
            first_o <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (period_end) begin
            ph      <= '0;
            first_o <= 1'b0;
            if (run_i && cand_ok) begin
              sh_per_o  <= c_per_i;
              sh_high_o <= c_high_i;
              sh_off_o  <= c_off_i;
              sh_len_o  <= c_len_i;
            end
          end else begin
            ph <= ph + PW'(1);
          end
          if (!run_i) st <= ST_STOP;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st;
  assign ph_o    = ph;

  // R6: a refused start leaves the sequencer idle
  a_r6_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start_evt && !c_conv_ok_i) |=> (st == ST_IDLE));

  // R9: the period in use only moves at a boundary
  a_r9_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && ph != '0) |-> $stable(sh_per_o));

endmodule

// File: rtl/tg_wave_decode.sv
module tg_wave_decode
  import cnv_gate_pkg::*;
#(
  parameter int PW = 9
) (
  input  tg_state_e     state_i,
  input  logic [PW-1:0] ph_i,
  input  logic          first_i,
  input  logic [PW-1:0] per_i,
  input  logic [PW-1:0] high_i,
  input  logic [PW-1:0] off_i,
  input  logic [PW-1:0] len_i,
  output logic          conv_o,
  output logic          gate_o
);

  logic in_high;
  logic in_gate;

  assign in_high = (ph_i < high_i);
  assign in_gate = in_window(int'(ph_i), int'(off_i), int'(len_i), int'(per_i), first_i);

  always_comb begin
    conv_o = 1'b0;
    gate_o = 1'b0;
    case (state_i)
      ST_RUN: begin
        conv_o = in_high;
        gate_o = in_gate;
      end
      // Stopping: gate already off; only an ongoing pulse may finish this cycle.
      ST_STOP: conv_o = in_high && (ph_i != '0);
      default: ;
    endcase
  end

endmodule

// File: rtl/cnv_gate_timer.sv
module cnv_gate_timer
  import cnv_gate_pkg::*;
#(
  parameter int CFGW  = 16,
  parameter int BW    = 5,
  parameter int QW    = 6,
  parameter int QFRAC = 2,
  parameter int PMIN  = 5,
  parameter int PMAX  = 500,
  localparam int PW   = $clog2(PMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [CFGW-1:0] cfg_period_i,
  input  logic [CFGW-1:0] cfg_high_i,
  input  logic [CFGW-1:0] cfg_offset_i,
  input  logic [BW-1:0]   cfg_bits_i,
  input  logic [QW-1:0]   cfg_bclk_q_i,
  output logic            conv_o,
  output logic            gate_o,
  output logic            busy_o,
  output logic [PW-1:0]   act_period_o
);

  logic [PW-1:0] c_per, c_high, c_off, c_len;
  logic          c_conv_ok, c_gate_ok;
  tg_state_e     st;
  logic [PW-1:0] ph;
  logic          first;
  logic [PW-1:0] sh_per, sh_high, sh_off, sh_len;

  tg_cfg_eval #(
    .CFGW(CFGW), .BW(BW), .QW(QW), .QFRAC(QFRAC),
    .PMIN(PMIN), .PMAX(PMAX), .PW(PW)
  ) u_eval (
    .cfg_period_i(cfg_period_i),
    .cfg_high_i  (cfg_high_i),
    .cfg_offset_i(cfg_offset_i),
    .cfg_bits_i  (cfg_bits_i),
    .cfg_bclk_q_i(cfg_bclk_q_i),
    .per_o       (c_per),
    .high_o      (c_high),
    .off_o       (c_off),
    .len_o       (c_len),
    .conv_ok_o   (c_conv_ok),
    .gate_ok_o   (c_gate_ok)
  );

  tg_sequencer #(.PW(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .c_per_i    (c_per),
    .c_high_i   (c_high),
    .c_off_i    (c_off),
    .c_len_i    (c_len),
    .c_conv_ok_i(c_conv_ok),
    .c_gate_ok_i(c_gate_ok),
    .state_o    (st),
    .ph_o       (ph),
    .first_o    (first),
    .sh_per_o   (sh_per),
    .sh_high_o  (sh_high),
    .sh_off_o   (sh_off),
    .sh_len_o   (sh_len)
  );

  tg_wave_decode #(.PW(PW)) u_dec (
    .state_i(st),
    .ph_i   (ph),
    .first_i(first),
    .per_i  (sh_per),
    .high_i (sh_high),
    .off_i  (sh_off),
    .len_i  (sh_len),
    .conv_o (conv_o),
    .gate_o (gate_o)
  );

  assign busy_o       = (st != ST_IDLE);
  assign act_period_o = sh_per;

  // R3: no conversion pulse outside an active run
  a_r3_conv_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> busy_o);

  // R2: the period in use is always inside the saturation range
  a_r2_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (int'(act_period_o) >= PMIN && int'(act_period_o) <= PMAX));

  // R8: the gate is already closed in the last busy cycle
  a_r8_gate_first_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !$past(gate_o));

  // R10: busy only rises after run was sampled high
  a_r10_busy_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(run_i));

endmodule

// File: tb/cnv_gate_timer_test.sv
module cnv_gate_timer_test;

  localparam int CFGW = 16;
  localparam int BW   = 5;
  localparam int QW   = 6;
  localparam int PMIN = 5;
  localparam int PMAX = 500;
  localparam int PW   = $clog2(PMAX + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            run = 1'b0;
  logic [CFGW-1:0] cfg_period = '0;
  logic [CFGW-1:0] cfg_high = '0;
  logic [CFGW-1:0] cfg_offset = '0;
  logic [BW-1:0]   cfg_bits = '0;
  logic [QW-1:0]   cfg_q = '0;
  logic            conv, gate, busy;
  logic [PW-1:0]   act_period;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  cnv_gate_timer #(.CFGW(CFGW), .BW(BW), .QW(QW), .PMIN(PMIN), .PMAX(PMAX)) uut (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .cfg_period_i(cfg_period), .cfg_high_i(cfg_high), .cfg_offset_i(cfg_offset),
    .cfg_bits_i(cfg_bits), .cfg_bclk_q_i(cfg_q),
    .conv_o(conv), .gate_o(gate), .busy_o(busy), .act_period_o(act_period)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, actual, expected, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_mode;          // 0 idle, 1 arming, 2 running, 3 stopping
  bit  m_prev_run;
  int  m_pos, m_per, m_high, m_off, m_len;
  bit  m_gate_good, m_fresh;

  function automatic int sat_period(input int r);
    int v;
    v = r;
    if (v > PMAX) v = PMAX;
    if (v < PMIN) v = PMIN;
    return v;
  endfunction

  function automatic int want_len(input int b, input int q);
    int num;
    num = b * q;
    return (num % 4 == 0) ? num / 4 : num / 4 + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_prev_run = 0; m_pos = 0; m_fresh = 0;
      m_per = 0; m_high = 0; m_off = 0; m_len = 0; m_gate_good = 0;
    end else begin
      int p, l;
      bit hi_ok, gt_ok, edge_seen, wrap_now;
      p = sat_period(int'(cfg_period));
      l = want_len(int'(cfg_bits), int'(cfg_q));
      hi_ok = (cfg_high > 0) && (int'(cfg_high) < p);
      gt_ok = (int'(cfg_offset) < p) && (l > 0) && (l < p);
      edge_seen = run && !m_prev_run;
      case (m_mode)
        0: if (edge_seen && hi_ok) begin
             m_per = p; m_high = int'(cfg_high); m_off = int'(cfg_offset);
             m_len = l; m_gate_good = gt_ok; m_mode = 1;
           end
        1: if (run && m_gate_good) begin m_mode = 2; m_pos = 0; m_fresh = 1; end
           else m_mode = 0;
        2: begin
             wrap_now = (m_pos + 1 == m_per);
             if (wrap_now) begin
               m_pos = 0; m_fresh = 0;
               if (run && hi_ok && gt_ok) begin
                 m_per = p; m_high = int'(cfg_high); m_off = int'(cfg_offset); m_len = l;
               end
             end else m_pos++;
             if (!run) m_mode = 3;
           end
        default: m_mode = 0;
      endcase
      m_prev_run = run;
    end
  end

  function automatic bit exp_gate();
    int d;
    if (m_mode != 2) return 0;
    d = (m_pos - m_off + m_per) % m_per;
    if (d >= m_len) return 0;
    if (m_fresh && m_pos < m_off) return 0;
    return 1;
  endfunction

  function automatic bit exp_conv();
    if (m_mode == 2) return m_pos < m_high;
    if (m_mode == 3) return (m_pos != 0) && (m_pos < m_high);
    return 0;
  endfunction

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(conv == exp_conv(), "R3 conv_o", int'(conv), int'(exp_conv()));
      check(gate == exp_gate(), "R4 gate_o", int'(gate), int'(exp_gate()));
      check(busy == (m_mode != 0), "R10 busy_o", int'(busy), int'(m_mode != 0));
      check(int'(act_period) == m_per, "R2 act_period_o", int'(act_period), m_per);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_cfg(input int p, input int h, input int o, input int b, input int q);
    cfg_period = CFGW'(p); cfg_high = CFGW'(h); cfg_offset = CFGW'(o);
    cfg_bits = BW'(b); cfg_q = QW'(q);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi, output int off, output int glen);
    logic pc;
    int t, r1, r2;
    pc = conv; t = 0; r1 = -1; r2 = -1; hi = 0; off = -1; glen = 0;
    while (r2 < 0 && t < 3000) begin
      @(negedge clk);
      t++;
      if (conv && !pc) begin
        if (r1 < 0) r1 = t; else r2 = t;
      end
      if (r1 >= 0 && r2 < 0) begin
        if (conv) hi++;
        if (gate) begin
          if (off < 0) off = t - r1;
          glen++;
        end
      end
      pc = conv;
    end
    per = r2 - r1;
  endtask

  task automatic wait_conv_rise();
    logic pc;
    pc = conv;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (conv && !pc) break;
      pc = conv;
    end
  endtask

  initial begin
    int per, hi, off, glen, nb, nc, ng;

    // R1: reset state
    #5;
    check(conv == 0 && gate == 0 && busy == 0, "R1 outputs low", int'({conv, gate, busy}), 0);
    check(act_period == 0, "R1 act_period", int'(act_period), 0);
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R6: zero high time and high time equal to period are refused
    set_cfg(20, 0, 3, 16, 4);
    run = 1'b1;
    nb = 0;
    for (int i = 0; i < 5; i++) begin wait_cyc(1); if (busy) nb++; end
    check(nb == 0, "R6 zero high refused", nb, 0);
    run = 1'b0; wait_cyc(2);
    set_cfg(20, 20, 3, 16, 4);
    run = 1'b1;
    nb = 0;
    for (int i = 0; i < 5; i++) begin wait_cyc(1); if (busy) nb++; end
    check(nb == 0, "R6 high==period refused", nb, 0);
    run = 1'b0; wait_cyc(2);

    // R7: bad gate offset: one busy cycle, no edges; held run does not retry (R10)
    set_cfg(20, 2, 25, 16, 4);
    run = 1'b1;
    nb = 0; nc = 0; ng = 0;
    for (int i = 0; i < 8; i++) begin
      wait_cyc(1);
      if (busy) nb++;
      if (conv) nc++;
      if (gate) ng++;
    end
    check(nb == 1, "R7 busy one cycle", nb, 1);
    check(nc == 0 && ng == 0, "R7 no edges", nc + ng, 0);
    run = 1'b0; wait_cyc(2);

    // R3/R4: plain window
    set_cfg(40, 3, 5, 16, 4);
    run = 1'b1;
    measure(per, hi, off, glen);
    check(per == 40, "R3 period", per, 40);
    check(hi == 3, "R3 high time", hi, 3);
    check(off == 5, "R4 gate offset", off, 5);
    check(glen == 16, "R4 gate length", glen, 16);

    // R9/R4: reconfigure mid-run, 18 bits at 1.25 cycles -> 23 (rounded up)
    wait_cyc(7);
    set_cfg(40, 3, 10, 18, 5);
    measure(per, hi, off, glen);
    check(off == 10, "R9 new offset at boundary", off, 10);
    check(glen == 23, "R4 rounded length", glen, 23);

    // R9: invalid new set is ignored
    set_cfg(40, 3, 50, 18, 5);
    measure(per, hi, off, glen);
    check(per == 40 && off == 10, "R9 invalid set ignored", off, 10);
    run = 1'b0; wait_cyc(3);

    // R2: saturation low and high
    set_cfg(3, 1, 0, 2, 6);
    run = 1'b1; wait_cyc(4);
    check(act_period == 5, "R2 low clamp", int'(act_period), 5);
    measure(per, hi, off, glen);
    check(per == 5, "R2 clamped period", per, 5);
    run = 1'b0; wait_cyc(3);
    set_cfg(9999, 4, 0, 18, 5);
    run = 1'b1; wait_cyc(4);
    check(act_period == 500, "R2 high clamp", int'(act_period), 500);
    wait_cyc(700);
    run = 1'b0; wait_cyc(3);

    // R5: wrapped window suppressed in first period, present afterwards
    set_cfg(20, 2, 7, 16, 4);
    run = 1'b1;
    wait_conv_rise();
    check(gate == 0, "R5 no wrap in first period", int'(gate), 0);
    wait_conv_rise();
    check(gate == 1, "R5 wrap into next period", int'(gate), 1);
    wait_cyc(30);

    // R8: stop while the gate is open
    for (int i = 0; i < 40; i++) begin
      if (gate) break;
      wait_cyc(1);
    end
    run = 1'b0;
    wait_cyc(1);
    check(gate == 0, "R8 gate off first", int'(gate), 0);
    wait_cyc(1);
    check(conv == 0 && busy == 0, "R8 fully stopped", int'({conv, busy}), 0);
    wait_cyc(5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule